// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds the configuration bytes of a converter-style device behind a simple byte-wide register port, such as the parallel side of a decoded serial register bus. Every write names one 8-bit address and one data byte. Reads are combinational on the same address lines.

Most registers are double-buffered. A write to one of them changes only a pending (shadow) byte. The live (active) byte that drives the device changes only when software writes the transfer register, and then every pending byte moves into its live byte in the same clock. A short fixed list of addresses skips the buffering, so a write to one of them takes effect at once.

Reset loads a defined default into every register. The outputs are the live bytes and a read-back path. Software can read a pending byte back before it issues the transfer.

Top module: `shadow_cfg_bank`

## Requirements
- R1: While reset is low and after it is released, the live buffered slots hold, for slots 0 to 5 (addresses 0x08, 0x09, 0x0D, 0x10, 0x14, 0x22), the values 0x00, 0x01, 0x00, 0x00, 0x01, 0x00. The direct slots 0 to 3 (addresses 0x00, 0x02, 0x04, 0x05) hold 0x18, 0x00, 0x0F, 0x3F. Slot i occupies bits [8i+7:8i] of its output bus.
- R2: A write to direct address 0x00, 0x02, 0x04 or 0x05 appears on `directVals` right after the clock edge that accepts it.
- R3: A write to a buffered address changes only the pending byte. `activeVals` stays unchanged until a transfer.
- R4: A read of a buffered address returns the pending byte. A read of a direct address returns its live byte.
- R5: Writing 0xFF with data bit 0 set accepts a transfer. At the next clock edge, all six live buffered bytes take the pending values at once. Writing 0xFF with bit 0 clear does nothing.
- R6: `stabEnable` equals bit 0 of the live byte at address 0x09. Clearing that bit and then issuing a transfer drives `stabEnable` low.
- R7: A read of 0xFF returns 0x01 in the single cycle between the accepting edge and the commit edge, and 0x00 at all other times. Bits 7:1 always read 0.
- R8: A write to any other address has no effect on any output, and a read of such an address returns 0x00.
- R9: A buffered write accepted on the commit edge updates the pending byte. That value reaches the live byte only at a later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| regAddr | input | 8 | Register address for write and read |
| wrEn | input | 1 | Write strobe for the byte on wrData |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read-back of regAddr |
| activeVals | output | 48 | Live buffered bytes, slot i at [8i+7:8i] |
| directVals | output | 32 | Live direct bytes, slot i at [8i+7:8i] |
| stabEnable | output | 1 | Duty-cycle stabilizer enable, live 0x09 bit 0 |

## Verification
The assertions take for granted that `regAddr`, `wrEn` and `wrData` hold steady around each rising edge. They also assume reset is asserted long enough for one edge to load the defaults. The stimulus changes inputs one nanosecond after each rising edge. It then mixes directed sequences (a pending write, a transfer, a write landing on the commit edge, back-to-back transfers) with random writes. Those random writes cover valid, transfer and undefined addresses. A behavioural model checks every read and every live output on each falling edge.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int NUM_BUF   = 6;
  localparam int NUM_DIR   = 4;
  localparam int STAB_IDX  = 1;
  localparam logic [ADDR_W-1:0] XFER_ADDR = 8'hFF;

  typedef struct packed {
    logic [NUM_BUF-1:0] shadowWe;
    logic [NUM_DIR-1:0] directWe;
    logic [NUM_BUF-1:0] rdBuf;
    logic [NUM_DIR-1:0] rdDir;
    logic               rdXfer;
    logic               commit;
  } bankStrobes_t;

  function automatic logic [ADDR_W-1:0] bufAddr(input int idx);
    case (idx)
      0: return 8'h08;
      1: return 8'h09;
      2: return 8'h0D;
      3: return 8'h10;
      4: return 8'h14;
      default: return 8'h22;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] bufDefault(input int idx);
    case (idx)
      1: return 8'h01;
      4: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] dirAddr(input int idx);
    case (idx)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h04;
      default: return 8'h05;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] dirDefault(input int idx);
    case (idx)
      0: return 8'h18;
      2: return 8'h0F;
      3: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgbank_ctrl.sv
module cfgbank_ctrl
  import cfgbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output bankStrobes_t      strb
);
  logic xferBit;
  logic xferReq;

  assign xferReq = wrEn && (regAddr == XFER_ADDR) && wrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) xferBit <= 1'b0;
    else       xferBit <= xferReq;
  end

  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      strb.rdBuf[i]    = (regAddr == bufAddr(i));
      strb.shadowWe[i] = wrEn && strb.rdBuf[i];
    end
    for (int j = 0; j < NUM_DIR; j++) begin
      strb.rdDir[j]    = (regAddr == dirAddr(j));
      strb.directWe[j] = wrEn && strb.rdDir[j];
    end
    strb.rdXfer = (regAddr == XFER_ADDR);
    strb.commit = xferBit;
  end

  // R7: the transfer flag lasts one cycle unless a new transfer is written
  p_xfer_selfclear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferBit && !(wrEn && regAddr == XFER_ADDR && wrData[0])) |=> !xferBit);

  // R5: an accepted transfer is pending on the following cycle
  p_xfer_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == XFER_ADDR && wrData[0]) |=> strb.commit);

  // R3: a write addresses at most one pending byte
  p_single_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.shadowWe));
endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
  import cfgbank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  bankStrobes_t              strb,
  input  logic [DATA_W-1:0]         wrData,
  output logic [NUM_BUF*DATA_W-1:0] activeVals,
  output logic [NUM_DIR*DATA_W-1:0] directVals,
  output logic [DATA_W-1:0]         rdData
);
  logic [NUM_BUF-1:0][DATA_W-1:0] shadowQ;
  logic [NUM_BUF-1:0][DATA_W-1:0] activeQ;
  logic [NUM_DIR-1:0][DATA_W-1:0] directQ;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowQ[i] <= bufDefault(i);
        activeQ[i] <= bufDefault(i);
      end else begin
        if (strb.shadowWe[i]) shadowQ[i] <= wrData;
        if (strb.commit)      activeQ[i] <= shadowQ[i];
      end
    end
    assign activeVals[i*DATA_W +: DATA_W] = activeQ[i];
  end

  for (genvar j = 0; j < NUM_DIR; j++) begin : g_dir
    always_ff @(posedge clk) begin
      if (!rstN)                directQ[j] <= dirDefault(j);
      else if (strb.directWe[j]) directQ[j] <= wrData;
    end
    assign directVals[j*DATA_W +: DATA_W] = directQ[j];

    // R2: a direct write is live on the next cycle
    p_direct_now_r2: assert property (@(posedge clk) disable iff (!rstN)
      strb.directWe[j] |=> (directQ[j] == $past(wrData)));
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (strb.rdBuf[i]) rdData = shadowQ[i];
    for (int j = 0; j < NUM_DIR; j++)
      if (strb.rdDir[j]) rdData = directQ[j];
    if (strb.rdXfer) rdData = {{(DATA_W-1){1'b0}}, strb.commit};
  end

  // R3: live buffered bytes move only on a commit
  p_live_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(activeQ));

  // R5: a commit copies every pending byte in one edge
  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (activeQ == $past(shadowQ)));
endmodule

// File: rtl/shadow_cfg_bank.sv
module shadow_cfg_bank
  import cfgbank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic                      wrEn,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  output logic [NUM_BUF*DATA_W-1:0] activeVals,
  output logic [NUM_DIR*DATA_W-1:0] directVals,
  output logic                      stabEnable
);
  bankStrobes_t strb;

  cfgbank_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .strb(strb)
  );

  cfgbank_regs regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .activeVals(activeVals), .directVals(directVals), .rdData(rdData)
  );

  assign stabEnable = activeVals[STAB_IDX*DATA_W];

  // R6: stabilizer enable follows live 0x09 bit 0
  p_stab_track_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stabEnable == activeVals[STAB_IDX*DATA_W]) && (stabEnable == regs_i.activeQ[STAB_IDX][0]));
endmodule

// File: tb/shadow_cfg_bank_tb.sv
module shadow_cfg_bank_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [47:0] activeVals;
  logic [31:0] directVals;
  logic       stabEnable;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  string curReq = "R1";

  always #2 clk = ~clk;

  shadow_cfg_bank dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .activeVals(activeVals), .directVals(directVals),
    .stabEnable(stabEnable)
  );

  // ---- behavioural reference model ----
  int shadowM[256];
  int activeM[256];
  bit xferM;
  int bufList[6] = '{8'h08, 8'h09, 8'h0D, 8'h10, 8'h14, 8'h22};
  int bufDef[6]  = '{8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 8'h00};
  int dirList[4] = '{8'h00, 8'h02, 8'h04, 8'h05};
  int dirDef[4]  = '{8'h18, 8'h00, 8'h0F, 8'h3F};

  function automatic bit isBuf(int a);
    foreach (bufList[k]) if (bufList[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit isDir(int a);
    foreach (dirList[k]) if (dirList[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < 256; a++) begin shadowM[a] = 0; activeM[a] = 0; end
      foreach (bufList[k]) begin shadowM[bufList[k]] = bufDef[k]; activeM[bufList[k]] = bufDef[k]; end
      foreach (dirList[k]) activeM[dirList[k]] = dirDef[k];
      xferM = 1'b0;
    end else begin
      if (xferM) foreach (bufList[k]) activeM[bufList[k]] = shadowM[bufList[k]];
      xferM = 1'b0;
      if (wrEn) begin
        if (isBuf(regAddr)) shadowM[regAddr] = wrData;
        else if (isDir(regAddr)) activeM[regAddr] = wrData;
        else if (regAddr == 8'hFF && wrData[0]) xferM = 1'b1;
      end
    end
  end

  function automatic int expRead(int a);
    if (isBuf(a)) return shadowM[a];
    if (isDir(a)) return activeM[a];
    if (a == 8'hFF) return int'(xferM);
    return 0;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [47:0] ea;
      logic [31:0] ed;
      foreach (bufList[k]) ea[k*8 +: 8] = activeM[bufList[k]][7:0];
      foreach (dirList[k]) ed[k*8 +: 8] = activeM[dirList[k]][7:0];
      check(curReq, "activeVals", activeVals, ea);
      check(curReq, "directVals", directVals, ed);
      check(curReq, "rdData", rdData, expRead(regAddr));
      check("R6", "stabEnable", stabEnable, activeM[8'h09] & 1);
    end
  end

  // ---- stimulus ----
  task automatic wr(int a, int d);
    @(posedge clk); #1;
    regAddr = a[7:0]; wrData = d[7:0]; wrEn = 1'b1;
  endtask

  task automatic idle(int a);
    @(posedge clk); #1;
    regAddr = a[7:0]; wrEn = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    check("R1", "reset activeVals", activeVals, 48'h00_01_00_00_01_00);
    check("R1", "reset directVals", directVals, 32'h3F_0F_00_18);
    check("R6", "reset stabEnable", stabEnable, 1);

    curReq = "R2";
    wr(8'h04, 8'hA5); idle(8'h04);
    @(negedge clk); check("R2", "direct 0x04 live", directVals[23:16], 8'hA5);

    curReq = "R3";
    wr(8'h09, 8'h00); idle(8'h09);
    @(negedge clk);
    check("R4", "pending 0x09 read", rdData, 8'h00);
    check("R3", "live 0x09 unchanged", stabEnable, 1);

    curReq = "R5";
    wr(8'hFF, 8'h00); idle(8'hFF); idle(8'hFF);
    @(negedge clk); check("R5", "bit0 clear no commit", stabEnable, 1);
    wr(8'hFF, 8'h01); idle(8'hFF);
    @(negedge clk); check("R7", "xfer flag read", rdData, 8'h01);
    idle(8'hFF);
    @(negedge clk);
    check("R7", "xfer flag cleared", rdData, 8'h00);
    check("R6", "stabilizer off", stabEnable, 0);

    curReq = "R8";
    wr(8'h03, 8'hAA); idle(8'h03);
    @(negedge clk); check("R8", "reserved read", rdData, 8'h00);
    wr(8'h80, 8'h55); idle(8'h80);

    curReq = "R9";
    wr(8'hFF, 8'h01); wr(8'h14, 8'h5A); idle(8'h14);
    @(negedge clk);
    check("R9", "pending kept", rdData, 8'h5A);
    check("R9", "live not taken", activeVals[39:32], 8'h01);
    wr(8'hFF, 8'h01); idle(8'h14); idle(8'h14);
    @(negedge clk); check("R9", "taken next transfer", activeVals[39:32], 8'h5A);

    curReq = "R5";
    wr(8'hFF, 8'h01); wr(8'hFF, 8'h01); idle(8'hFF); idle(8'hFF);

    curReq = "R4";
    for (int i = 0; i < 3000; i++) begin
      int pick = $urandom_range(0, 13);
      int a;
      if (pick < 6) a = bufList[pick];
      else if (pick < 10) a = dirList[pick-6];
      else if (pick < 11) a = 8'hFF;
      else a = $urandom_range(0, 255);
      if ($urandom_range(0, 3) != 0) wr(a, $urandom_range(0, 255));
      else idle(a);
    end
    idle(8'h00);
    for (int a = 0; a < 256; a++) idle(a);
    idle(8'h00);
    @(negedge clk);
    finish_run();
  end
endmodule